// File: doc/BRIEF.md
# Delayed-Transfer Fetch Address Sequencer

This block produces the instruction fetch address for a core that always fetches the next instruction while the current one executes. Each cycle that is not held, the instruction presented on the control-transfer inputs is the one now executing. The sequencer then moves the already fetched instruction into the executing slot and picks the next fetch address. A taken transfer only redirects the fetch that follows, so the instruction placed directly after any jump, call or return (the delay slot) always runs.

Calls record their own address as a link value and raise a one-cycle strobe that moves the register window one frame deeper. Returns raise a strobe that moves it one frame back. The sequencer also keeps the address of the previously executed instruction, so a trap handler can restart correctly across a delay slot. A hold input freezes the whole sequencer for the extra cycle of a load or store.

Top module: `pcs_seq`

## Requirements
- R1: While reset is low, fetch_addr equals RST_ADDR and last_pc, link_addr, win_push and win_pop are zero. The first non-held cycle after reset has no instruction executing, so its control-transfer inputs are ignored and fetch_addr steps by INC.
- R2: In a non-held cycle with no taken transfer, fetch_addr advances by INC on the clock edge, modulo 2^AW.
- R3: When a taken transfer executes at address A, fetch_addr becomes the target on that edge. The instruction at A+INC, which was already fetched, is the next to execute.
- R4: xfer_kind codes are 0 none, 1 register jump, 2 relative jump, 3 register call, 4 relative call, 5 return. Register forms target base_val plus offset. Relative forms target the executing instruction's address plus offset. The offset is sign-extended from RELW bits.
- R5: Jumps are taken only when cond_sel passes. flags bits are [3] negative, [2] zero, [1] overflow, [0] carry (set means unsigned lower). cond_sel codes: 0 always, 1 zero, 2 not zero, 3 signed less, 4 signed greater-or-equal, 5 signed less-or-equal, 6 signed greater, 7 unsigned lower, 8 unsigned higher-or-same, 9 unsigned lower-or-same, 10 unsigned higher, 11 overflow, 12 no overflow, 13 negative, 14 positive, 15 never.
- R6: Calls ignore cond_sel and are always taken. For the cycle after a call executes, win_push is high, and link_addr holds the call's address until the next call.
- R7: A return is always taken. For the cycle after it executes, win_pop is high.
- R8: While hold is high, fetch_addr, last_pc and link_addr keep their values, win_push and win_pop are low, and the transfer inputs are ignored.
- R9: After each non-held cycle, last_pc holds the address of the instruction that executed in that cycle.
- R10: A taken transfer in a delay slot uses the first target as its own delay slot. The first target executes once, and then the second target executes.
- R11: xfer_kind codes 6 and 7 act as no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Freeze sequencing this cycle |
| xfer_kind | input | 3 | Control-transfer type of the executing instruction |
| cond_sel | input | 4 | Jump condition code |
| flags | input | 4 | Condition codes N, Z, V, C |
| base_val | input | AW | Register base for register-relative targets |
| offset | input | RELW | Signed displacement |
| fetch_addr | output | AW | Address being fetched |
| last_pc | output | AW | Address of the previously executed instruction |
| link_addr | output | AW | Address of the most recent call |
| win_push | output | 1 | Window step deeper (one cycle after a call) |
| win_pop | output | 1 | Window step back (one cycle after a return) |

## Verification
The bench builds the block with AW=16, RELW=8, INC=4 and RST_ADDR=0x0100. A 16-bit address space makes fetch wrap-around reachable with one jump to 0xFFF8. An 8-bit displacement lets a single offset byte exercise both sign extension and backward relative targets. All sixteen condition codes are swept against four flag patterns, and transfers are placed back to back in delay slots.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [2:0] {
        XF_NONE  = 3'd0,
        XF_JMP   = 3'd1,
        XF_JMPR  = 3'd2,
        XF_CALL  = 3'd3,
        XF_CALLR = 3'd4,
        XF_RET   = 3'd5
    } xfer_e;

    localparam int FL_N = 3;
    localparam int FL_Z = 2;
    localparam int FL_V = 1;
    localparam int FL_C = 0;
endpackage

// File: rtl/pcs_cond_eval.sv
module pcs_cond_eval
    import pcs_pkg::*;
(
    input  logic [3:0] cond_sel,
    input  logic [3:0] flags,
    output logic       pass
);
    logic neg, zer, ovf, cry, slt;

    always_comb begin
        neg = flags[FL_N];
        zer = flags[FL_Z];
        ovf = flags[FL_V];
        cry = flags[FL_C];
        slt = neg ^ ovf;
        unique case (cond_sel)
            4'd0:    pass = 1'b1;
            4'd1:    pass = zer;
            4'd2:    pass = ~zer;
            4'd3:    pass = slt;
            4'd4:    pass = ~slt;
            4'd5:    pass = slt | zer;
            4'd6:    pass = ~(slt | zer);
            4'd7:    pass = cry;
            4'd8:    pass = ~cry;
            4'd9:    pass = cry | zer;
            4'd10:   pass = ~(cry | zer);
            4'd11:   pass = ovf;
            4'd12:   pass = ~ovf;
            4'd13:   pass = neg;
            4'd14:   pass = ~neg;
            default: pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcs_target_gen.sv
module pcs_target_gen #(
    parameter int AW   = 32,
    parameter int RELW = 19
) (
    input  logic [AW-1:0]   exec_pc,
    input  logic [AW-1:0]   base_val,
    input  logic [RELW-1:0] offset,
    input  logic            pc_rel,
    output logic [AW-1:0]   target
);
    logic [AW-1:0] ofs_x;

    generate
        if (RELW < AW) begin : g_ext
            assign ofs_x = {{(AW-RELW){offset[RELW-1]}}, offset};
        end else begin : g_trunc
            assign ofs_x = offset[AW-1:0];
        end
    endgenerate

    assign target = (pc_rel ? exec_pc : base_val) + ofs_x;
endmodule

// File: rtl/pcs_seq.sv
module pcs_seq
    import pcs_pkg::*;
#(
    parameter int AW       = 32,
    parameter int RELW     = 19,
    parameter int INC      = 4,
    parameter int RST_ADDR = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [2:0]      xfer_kind,
    input  logic [3:0]      cond_sel,
    input  logic [3:0]      flags,
    input  logic [AW-1:0]   base_val,
    input  logic [RELW-1:0] offset,
    output logic [AW-1:0]   fetch_addr,
    output logic [AW-1:0]   last_pc,
    output logic [AW-1:0]   link_addr,
    output logic            win_push,
    output logic            win_pop
);
    localparam logic [AW-1:0] STEP_V  = AW'(INC);
    localparam logic [AW-1:0] START_V = AW'(RST_ADDR);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] npc;
        logic [AW-1:0] lpc;
        logic [AW-1:0] link;
        logic          vld;
        logic          push;
        logic          pop;
    } seq_t;

    seq_t          s_d, s_q;
    logic          cond_ok;
    logic          rel_sel;
    logic [AW-1:0] tgt;

    pcs_cond_eval u_cond (
        .cond_sel (cond_sel),
        .flags    (flags),
        .pass     (cond_ok)
    );

    assign rel_sel = (xfer_kind == XF_JMPR) || (xfer_kind == XF_CALLR);

    pcs_target_gen #(.AW(AW), .RELW(RELW)) u_tgt (
        .exec_pc  (s_q.pc),
        .base_val (base_val),
        .offset   (offset),
        .pc_rel   (rel_sel),
        .target   (tgt)
    );

    always_comb begin
        s_d      = s_q;
        s_d.push = 1'b0;
        s_d.pop  = 1'b0;
        if (!hold) begin
            s_d.lpc = s_q.pc;
            s_d.pc  = s_q.npc;
            s_d.vld = 1'b1;
            s_d.npc = s_q.npc + STEP_V;
            if (s_q.vld) begin
                case (xfer_kind)
                    XF_JMP, XF_JMPR: begin
                        if (cond_ok) s_d.npc = tgt;
                    end
                    XF_CALL, XF_CALLR: begin
                        s_d.npc  = tgt;
                        s_d.link = s_q.pc;
                        s_d.push = 1'b1;
                    end
                    XF_RET: begin
                        s_d.npc = tgt;
                        s_d.pop = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pc   <= '0;
            s_q.npc  <= START_V;
            s_q.lpc  <= '0;
            s_q.link <= '0;
            s_q.vld  <= 1'b0;
            s_q.push <= 1'b0;
            s_q.pop  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_addr = s_q.npc;
    assign last_pc    = s_q.lpc;
    assign link_addr  = s_q.link;
    assign win_push   = s_q.push;
    assign win_pop    = s_q.pop;
endmodule

// File: rtl/pcs_seq_chk.sv
module pcs_seq_chk
    import pcs_pkg::*;
#(
    parameter int AW  = 32,
    parameter int INC = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hold,
    input logic [2:0]    xfer_kind,
    input logic [AW-1:0] fetch_addr,
    input logic [AW-1:0] last_pc,
    input logic [AW-1:0] link_addr,
    input logic          win_push,
    input logic          win_pop
);
    localparam logic [AW-1:0] STEP_V = AW'(INC);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && xfer_kind == XF_NONE) |=> fetch_addr == $past(fetch_addr) + STEP_V);

    p_push_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        win_push |-> ($past(!hold) && ($past(xfer_kind) == XF_CALL || $past(xfer_kind) == XF_CALLR)));

    p_pop_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        win_pop |-> ($past(!hold) && $past(xfer_kind) == XF_RET));

    p_hold_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(fetch_addr) && $stable(last_pc) && $stable(link_addr) && !win_push && !win_pop));

    p_last_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold ##1 !hold) |=> last_pc == $past(fetch_addr, 2));
endmodule

bind pcs_seq pcs_seq_chk #(.AW(AW), .INC(INC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .xfer_kind  (xfer_kind),
    .fetch_addr (fetch_addr),
    .last_pc    (last_pc),
    .link_addr  (link_addr),
    .win_push   (win_push),
    .win_pop    (win_pop)
);

// File: tb/sim_pcs_seq.sv
`timescale 1ns/1ps
module sim_pcs_seq;
    localparam int AW = 16;
    localparam int RELW = 8;
    localparam int INC = 4;
    localparam int RST_ADDR = 'h0100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            hold = 1'b1;
    logic [2:0]      xfer_kind = 3'd0;
    logic [3:0]      cond_sel = 4'd0;
    logic [3:0]      flags = 4'd0;
    logic [AW-1:0]   base_val = '0;
    logic [RELW-1:0] offset = '0;
    logic [AW-1:0]   fetch_addr, last_pc, link_addr;
    logic            win_push, win_pop;

    always #5 clk = ~clk;

    pcs_seq #(.AW(AW), .RELW(RELW), .INC(INC), .RST_ADDR(RST_ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .hold(hold), .xfer_kind(xfer_kind),
        .cond_sel(cond_sel), .flags(flags), .base_val(base_val), .offset(offset),
        .fetch_addr(fetch_addr), .last_pc(last_pc), .link_addr(link_addr),
        .win_push(win_push), .win_pop(win_pop)
    );

    typedef struct {
        logic [AW-1:0] f;
        logic [AW-1:0] l;
        logic [AW-1:0] k;
        logic          p;
        logic          o;
        string         tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [AW-1:0] m_pc, m_npc, m_lpc, m_link;
    logic          m_vld;

    function automatic logic cond_expect(input logic [3:0] c, input logic [3:0] fl);
        logic n, z, v, cy;
        n = fl[3]; z = fl[2]; v = fl[1]; cy = fl[0];
        case (c)
            4'd0:  return 1'b1;
            4'd1:  return z;
            4'd2:  return !z;
            4'd3:  return n != v;
            4'd4:  return n == v;
            4'd5:  return z || (n != v);
            4'd6:  return !z && (n == v);
            4'd7:  return cy;
            4'd8:  return !cy;
            4'd9:  return cy || z;
            4'd10: return !cy && !z;
            4'd11: return v;
            4'd12: return !v;
            4'd13: return n;
            4'd14: return !n;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_one(input string tag, input string what,
                             input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] k, input logic [3:0] c, input logic [3:0] fl,
                        input logic [AW-1:0] b, input logic [RELW-1:0] o,
                        input logic h, input string tag);
        exp_t e;
        logic [AW-1:0] ox, tgt;
        logic tk;
        @(negedge clk);
        xfer_kind = k; cond_sel = c; flags = fl; base_val = b; offset = o; hold = h;
        e.p = 1'b0; e.o = 1'b0;
        if (!h) begin
            ox  = AW'($signed(o));
            tk  = 1'b0;
            tgt = '0;
            if (m_vld) begin
                if (k == 3'd1 || k == 3'd3 || k == 3'd5) tgt = b + ox;
                else tgt = m_pc + ox;
                if (k == 3'd1 || k == 3'd2) tk = cond_expect(c, fl);
                if (k == 3'd3 || k == 3'd4) begin tk = 1'b1; e.p = 1'b1; m_link = m_pc; end
                if (k == 3'd5) begin tk = 1'b1; e.o = 1'b1; end
            end
            m_lpc = m_pc;
            m_pc  = m_npc;
            m_npc = tk ? tgt : m_npc + AW'(INC);
            m_vld = 1'b1;
        end
        e.f = m_npc; e.l = m_lpc; e.k = m_link; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                check_one(e.tag, "fetch_addr", fetch_addr, e.f);
                check_one(e.tag, "last_pc", last_pc, e.l);
                check_one(e.tag, "link_addr", link_addr, e.k);
                check_one(e.tag, "win_push", AW'(win_push), AW'(e.p));
                check_one(e.tag, "win_pop", AW'(win_pop), AW'(e.o));
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_pc = '0; m_npc = AW'(RST_ADDR); m_lpc = '0; m_link = '0; m_vld = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_one("R1", "fetch_addr", fetch_addr, AW'(RST_ADDR));
        check_one("R1", "last_pc", last_pc, '0);
        check_one("R1", "link_addr", link_addr, '0);
        check_one("R1", "strobes", AW'({win_push, win_pop}), '0);
        rst_n = 1'b1;
        // R1 first cycle: transfer inputs ignored
        step(3'd3, 4'd0, 4'd0, 16'h4000, 8'h00, 1'b0, "R1");
        // R2 sequential stepping
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R2");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R2");
        // R3 taken relative jump, then delay slot
        step(3'd2, 4'd0, 4'd0, '0, 8'h20, 1'b0, "R3");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R3");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R3");
        // R4 register jump with negative offset, backward relative jump
        step(3'd1, 4'd0, 4'd0, 16'h2000, 8'hF8, 1'b0, "R4");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R4");
        step(3'd2, 4'd0, 4'd0, '0, 8'hF0, 1'b0, "R4");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R4");
        // R5 all condition codes under several flag patterns
        for (int c = 0; c < 16; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [3:0] fl;
                fl = (p == 0) ? 4'b0000 : (p == 1) ? 4'b1111 : (p == 2) ? 4'b0101 : 4'b1010;
                step(3'd2, 4'(c), fl, '0, 8'h10, 1'b0, "R5");
            end
        end
        // R6 calls are unconditional
        step(3'd4, 4'd15, 4'd0, '0, 8'h40, 1'b0, "R6");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R6");
        step(3'd3, 4'd15, 4'd0, 16'h3000, 8'h04, 1'b0, "R6");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R6");
        // R7 return
        step(3'd5, 4'd15, 4'd0, 16'h1234, 8'h08, 1'b0, "R7");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R7");
        // R8 hold freezes and ignores transfers
        step(3'd1, 4'd0, 4'd0, 16'h5000, 8'h00, 1'b1, "R8");
        step(3'd3, 4'd0, 4'd0, 16'h5000, 8'h00, 1'b1, "R8");
        step(3'd5, 4'd0, 4'd0, 16'h5000, 8'h00, 1'b1, "R8");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R8");
        // R9 last_pc tracking
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R9");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R9");
        // R10 transfer inside a delay slot
        step(3'd2, 4'd0, 4'd0, '0, 8'h40, 1'b0, "R10");
        step(3'd2, 4'd0, 4'd0, '0, 8'h7C, 1'b0, "R10");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R10");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R10");
        // R11 unused kind codes
        step(3'd6, 4'd0, 4'd0, 16'h6000, 8'h10, 1'b0, "R11");
        step(3'd7, 4'd0, 4'd0, 16'h6000, 8'h10, 1'b0, "R11");
        // R2 wrap-around
        step(3'd1, 4'd0, 4'd0, 16'hFFF8, 8'h00, 1'b0, "R2");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R2");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R2");
        step(3'd0, 4'd0, 4'd0, '0, 8'h00, 1'b0, "R2");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule